// File: doc/BRIEF.md
# Bit-Addressable Internal Data Memory

This block is the on-chip data store and access unit of an 8-bit microcontroller core. It holds a 256-byte RAM, a small special-register space and a stack pointer. The low 32 bytes of RAM double as four register banks. A request port carries an access mode, an address or pointer select, write data and a bit value. A bank-select input picks the active register bank.

Byte accesses address memory in one of two ways. A direct access uses an 8-bit address, and from 80h upward it lands in the special-register space. An indirect access takes its address from R0 or R1 of the active bank, or from the stack pointer, and from 80h upward it lands in the upper half of RAM. Single-bit accesses decode an 8-bit bit address into either the RAM bit area or the bit-capable special registers. A bit write is performed as a two-cycle read-modify-write of the containing byte.

Top module: `idata_unit`

## Requirements
- R1: On synchronous reset every RAM byte and every special register becomes 00h, except the stack pointer, which becomes 07h. After reset `busy` and `rd_data` are 0.
- R2: Mode code 0 is direct access. An accepted direct read of an address from 00h to 7Fh returns that RAM byte on `rd_data` one clock after the request. A direct write stores `req_wdata` there.
- R3: A direct access from 80h to FFh selects the special-register space. The stack pointer sits at 81h. Addresses whose low three bits are 000 hold a register each. Every other address reads 00h and ignores writes.
- R4: Mode code 1 is indirect access. Pointer code 0 takes the address from RAM byte 8·bank, code 1 from 8·bank+1, and codes 2 and 3 from the stack pointer. The bank is the value on `bank_sel` in the same cycle as the request.
- R5: An indirect access to an address of 80h or above reaches RAM, never the special registers.
- R6: Mode code 2 is bit access. A bit address from 00h to 7Fh selects bit (a & 7) of RAM byte 20h + (a >> 3). A bit read returns that bit in `rd_data[0]`, with bits 7..1 equal to zero.
- R7: A bit address from 80h to FFh selects bit (a & 7) of the special register at (a & F8h). Bit accesses never reach the stack pointer.
- R8: A bit write changes only the addressed bit. `busy` is high during the clock that follows the request. The byte holds its new value after that clock. A request presented while `busy` is high is ignored.
- R9: A write of any kind leaves `rd_data` unchanged. Mode code 3 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_mode | input | 2 | 0 direct, 1 indirect, 2 bit, 3 none |
| req_we | input | 1 | 1 for write, 0 for read |
| req_addr | input | 8 | Direct byte address or bit address |
| req_ptr | input | 2 | Indirect pointer: 0 R0, 1 R1, 2/3 stack pointer |
| req_wdata | input | 8 | Byte write data |
| req_bit | input | 1 | Value for a bit write |
| bank_sel | input | 2 | Active register bank |
| rd_data | output | 8 | Read result, registered |
| busy | output | 1 | Bit write-back cycle in progress |

## Verification
Two functions can fall in the same cycle: the write-back clock of a bit write and a fresh request. The bench drives a direct byte write to the very byte under modification during that `busy` clock. It then reads the byte back. The check passes only if the byte carries the bit change and not the intruding data. Random traffic also lets indirect writes rewrite R0, R1 and the stack pointer between requests, so that pointer resolution is judged against a bench model that follows every write.

// File: rtl/idata_unit.sv
module idata_unit #(
  parameter logic [7:0] SP_INIT = 8'h07
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  input  logic [1:0] req_mode,
  input  logic       req_we,
  input  logic [7:0] req_addr,
  input  logic [1:0] req_ptr,
  input  logic [7:0] req_wdata,
  input  logic       req_bit,
  input  logic [1:0] bank_sel,
  output logic [7:0] rd_data,
  output logic       busy
);
  localparam logic [1:0] M_DIR = 2'd0, M_IND = 2'd1, M_BIT = 2'd2;
  localparam logic [7:0] SP_ADDR = 8'h81;

  logic [7:0] ram [256];
  logic [7:0] sfr [16];
  logic [7:0] sp;
  logic [7:0] p_addr, p_data;
  logic       p_sfr;

  wire accept  = req_valid && !busy;
  wire bit_wr  = accept && req_mode == M_BIT && req_we;
  wire [7:0] ptr_val = req_ptr[1] ? sp : ram[{3'b000, bank_sel, 2'b00, req_ptr[0]}];

  logic [7:0] eff, cur, mask, wr_addr, wr_data;
  logic       eff_sfr, wr_en, wr_sfr;

  always_comb begin
    case (req_mode)
      M_IND:   eff = ptr_val;
      M_BIT:   eff = req_addr[7] ? {req_addr[7:3], 3'b000} : {4'h2, req_addr[6:3]};
      default: eff = req_addr;
    endcase
    eff_sfr = (req_mode != M_IND) && eff[7];
    if (!eff_sfr)               cur = ram[eff];
    else if (eff == SP_ADDR)    cur = sp;
    else if (eff[2:0] == 3'b0)  cur = sfr[eff[6:3]];
    else                        cur = 8'h00;
    mask = 8'h01 << req_addr[2:0];
  end

  always_comb begin
    wr_en = 1'b0; wr_sfr = 1'b0; wr_addr = 8'h00; wr_data = 8'h00;
    if (busy) begin
      wr_en = 1'b1; wr_sfr = p_sfr; wr_addr = p_addr; wr_data = p_data;
    end else if (accept && req_we && (req_mode == M_DIR || req_mode == M_IND)) begin
      wr_en = 1'b1; wr_sfr = eff_sfr; wr_addr = eff; wr_data = req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) ram[i] <= 8'h00;
      for (int i = 0; i < 16; i++)  sfr[i] <= 8'h00;
      sp <= SP_INIT;
      busy <= 1'b0; rd_data <= 8'h00;
      p_addr <= 8'h00; p_data <= 8'h00; p_sfr <= 1'b0;
    end else begin
      busy <= bit_wr;
      if (bit_wr) begin
        p_addr <= eff;
        p_sfr  <= eff_sfr;
        p_data <= req_bit ? (cur | mask) : (cur & ~mask);
      end
      if (accept && !req_we && req_mode != 2'd3)
        rd_data <= (req_mode == M_BIT) ? {7'b0, |(cur & mask)} : cur;
      if (wr_en) begin
        if (!wr_sfr)                   ram[wr_addr] <= wr_data;
        else if (wr_addr == SP_ADDR)   sp <= wr_data;
        else if (wr_addr[2:0] == 3'b0) sfr[wr_addr[6:3]] <= wr_data;
      end
    end
  end
endmodule

module idata_unit_chk (
  input logic       clk,
  input logic       rst,
  input logic       req_valid,
  input logic [1:0] req_mode,
  input logic       req_we,
  input logic [7:0] rd_data,
  input logic       busy
);
  wire acc = req_valid && !busy;

  a_r8_busy_single: assert property (@(posedge clk) disable iff (rst)
    busy |=> !busy);
  a_r8_busy_after_bitwrite: assert property (@(posedge clk) disable iff (rst)
    (acc && req_mode == 2'd2 && req_we) |=> busy);
  a_r8_busy_only_bitwrite: assert property (@(posedge clk) disable iff (rst)
    !(acc && req_mode == 2'd2 && req_we) |=> !busy);
  a_r8_ignored_while_busy: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(rd_data));
  a_r6_bitread_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (acc && req_mode == 2'd2 && !req_we) |=> rd_data[7:1] == 7'd0);
  a_r9_write_keeps_rdata: assert property (@(posedge clk) disable iff (rst)
    (acc && req_we) |=> $stable(rd_data));
endmodule

bind idata_unit idata_unit_chk u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_mode(req_mode),
  .req_we(req_we), .rd_data(rd_data), .busy(busy)
);

// File: tb/test_idata_unit.sv
module test_idata_unit;
  logic clk = 0, rst = 1, req_valid = 0, req_we = 0, req_bit = 0;
  logic [1:0] req_mode = 0, req_ptr = 0, bank_sel = 0;
  logic [7:0] req_addr = 0, req_wdata = 0;
  logic [7:0] rd_data;
  logic busy;
  int runs = 0, fails = 0;

  idata_unit i_idata_unit (.*);
  always #5 clk = ~clk;

  logic [7:0] m_ram [256];
  logic [7:0] m_sfr [16];
  logic [7:0] m_sp;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    runs++;
    if (!ok) begin fails++; $display("FAIL %s: got %0h expected %0h", tag, act, exp); end
  endtask

  function automatic logic [8:0] m_target(input logic [1:0] m, input logic [7:0] a,
                                          input logic [1:0] p, input logic [1:0] b);
    logic [7:0] t;
    if (m == 2'd1) begin
      t = p[1] ? m_sp : m_ram[8*b + p[0]];
      return {1'b0, t};
    end
    if (m == 2'd2) t = a[7] ? (a & 8'hF8) : (8'h20 + (a >> 3));
    else t = a;
    return {t[7], t};
  endfunction

  function automatic logic [7:0] m_get(input logic [8:0] t);
    if (!t[8]) return m_ram[t[7:0]];
    if (t[7:0] == 8'h81) return m_sp;
    if (t[2:0] == 3'b0) return m_sfr[t[6:3]];
    return 8'h00;
  endfunction

  task automatic m_put(input logic [8:0] t, input logic [7:0] d);
    if (!t[8]) m_ram[t[7:0]] = d;
    else if (t[7:0] == 8'h81) m_sp = d;
    else if (t[2:0] == 3'b0) m_sfr[t[6:3]] = d;
  endtask

  task automatic access(input logic [1:0] m, input bit we, input logic [7:0] a,
                        input logic [1:0] p, input logic [7:0] wd, input bit bv,
                        input logic [1:0] b, input string tag);
    logic [8:0] t; logic [7:0] e, prev;
    @(negedge clk);
    req_valid = 1; req_mode = m; req_we = we; req_addr = a; req_ptr = p;
    req_wdata = wd; req_bit = bv; bank_sel = b;
    t = m_target(m, a, p, b);
    e = m_get(t);
    prev = rd_data;
    @(negedge clk);
    req_valid = 0;
    if (m == 2'd3) chk(rd_data == prev, tag, rd_data, prev);
    else if (!we) begin
      if (m == 2'd2) chk(rd_data == {7'b0, e[a[2:0]]}, tag, rd_data, {7'b0, e[a[2:0]]});
      else chk(rd_data == e, tag, rd_data, e);
    end else if (m != 2'd2) begin
      m_put(t, wd);
      chk(rd_data == prev, {tag, " R9"}, rd_data, prev);
    end else begin
      e[a[2:0]] = bv;
      m_put(t, e);
      chk(busy == 1'b1, {tag, " R8 busy"}, busy, 1);
      @(negedge clk);
      chk(busy == 1'b0, {tag, " R8 busy end"}, busy, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got hang expected completion");
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) m_ram[i] = 0;
    for (int i = 0; i < 16; i++) m_sfr[i] = 0;
    m_sp = 8'h07;
    void'($urandom(32'd42));
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk(busy == 0 && rd_data == 0, "R1 outputs", {busy, rd_data}, 0);
    access(2'd0, 0, 8'h81, 0, 0, 0, 0, "R1 sp");
    access(2'd0, 0, 8'h45, 0, 0, 0, 0, "R1 ram");
    access(2'd0, 0, 8'hE0, 0, 0, 0, 0, "R1 sfr");
    // R2 direct RAM
    access(2'd0, 1, 8'h7F, 0, 8'hA5, 0, 0, "R2 wr");
    access(2'd0, 0, 8'h7F, 0, 0, 0, 0, "R2 rd");
    // R3 special space
    access(2'd0, 1, 8'h82, 0, 8'h5A, 0, 0, "R3 unimpl wr");
    access(2'd0, 0, 8'h82, 0, 0, 0, 0, "R3 unimpl rd");
    access(2'd0, 1, 8'h98, 0, 8'h3C, 0, 0, "R3 sfr wr");
    access(2'd0, 0, 8'h98, 0, 0, 0, 0, "R3 sfr rd");
    // R4 / R5 indirect with bank 2 R1 = 90h
    access(2'd0, 1, 8'h11, 0, 8'h90, 0, 0, "R4 set R1b2");
    access(2'd1, 1, 8'h00, 1, 8'h77, 0, 2'd2, "R5 ind wr 90h");
    access(2'd0, 0, 8'h90, 0, 0, 0, 0, "R5 direct 90h is sfr");
    access(2'd1, 0, 8'h00, 1, 0, 0, 2'd2, "R5 ind rd 90h");
    access(2'd1, 0, 8'h00, 1, 0, 0, 2'd0, "R4 bank0 R1");
    access(2'd1, 0, 8'h00, 2, 0, 0, 2'd3, "R4 sp ptr");
    // R6 bit RAM area
    access(2'd2, 1, 8'h7F, 0, 0, 0, 0, "R6 clr 7F");
    access(2'd0, 0, 8'h2F, 0, 0, 0, 0, "R6 byte 2F");
    access(2'd2, 1, 8'h00, 0, 0, 1, 0, "R6 set 00");
    access(2'd0, 0, 8'h20, 0, 0, 0, 0, "R6 byte 20");
    access(2'd2, 0, 8'h00, 0, 0, 0, 0, "R6 bit rd");
    // R7 bit in special space
    access(2'd2, 1, 8'hAB, 0, 0, 1, 0, "R7 set AB");
    access(2'd0, 0, 8'hA8, 0, 0, 0, 0, "R7 byte A8");
    access(2'd2, 0, 8'h99, 0, 0, 0, 0, "R7 bit 99");
    access(2'd2, 1, 8'h81, 0, 0, 1, 0, "R7 not sp");
    access(2'd0, 0, 8'h81, 0, 0, 0, 0, "R7 sp kept");
    // R9 mode 3
    access(2'd3, 1, 8'h40, 0, 8'hFF, 0, 0, "R9 mode3");
    access(2'd0, 0, 8'h40, 0, 0, 0, 0, "R9 mode3 no write");
    // R8 collision: request during busy clock targets same byte
    @(negedge clk);
    req_valid = 1; req_mode = 2'd2; req_we = 1; req_addr = 8'h0A; req_bit = 1;
    @(negedge clk);
    m_ram[8'h21][2] = 1'b1;
    chk(busy == 1, "R8 busy", busy, 1);
    req_mode = 2'd0; req_addr = 8'h21; req_wdata = 8'hEE;
    @(negedge clk);
    req_valid = 0;
    chk(busy == 0, "R8 no restart", busy, 0);
    access(2'd0, 0, 8'h21, 0, 0, 0, 0, "R8 ignored during busy");
    // random traffic
    for (int n = 0; n < 600; n++) begin
      logic [1:0] m;
      m = 2'($urandom_range(0, 3));
      access(m, 1'($urandom), 8'($urandom), 2'($urandom), 8'($urandom),
             1'($urandom), 2'($urandom), "R2 R3 R4 R6 R7 random");
    end
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule